// File: doc/BRIEF.md
# Manchester Word Decoder with Address Match

This block receives serial Manchester-coded words from a differential pair of line inputs: one input marks the positive bus state and one the negative. It finds the three-bit-time sync that opens every word and tells a command or status sync apart from a data sync. It then recovers the 16 data bits and the parity bit from fixed sample points that are timed from the middle edge of the sync. The recovered bits are presented MSB first as serial NRZ data inside an active-low take-data window. When that window closes, the word is moved into a holding register, which a subsystem reads one byte at a time through active-low selects.

After the parity bit, an active-low valid-word flag reports a word that has clean Manchester coding and odd parity. While that flag is low and the word carried a command sync, three decodes are driven: match on the terminal's own 5-bit address, the broadcast address, and the mode-code subaddress. A self-test select takes the decoder inputs from the local encoder's drive pair, so a terminal can check itself by wraparound. The default timing is 12 samples per bit time.

Top module: `manch_word_rx`

## Requirements
- R1: The positive line high with the negative line low is logic 1. The reverse is logic 0. Both lines high means idle. A data bit of value 1 is sent as the positive state for the first half-bit and the negative state for the second half-bit. A command sync is the positive state for 1.5 bit times and then the negative state for 1.5 bit times. A data sync is the same with the states swapped.
- R2: A receive cycle opens only after a sync and two Manchester-valid data bits have been seen. `take_data_no` is then low for exactly 16 bit times (16*SPB clocks). A coding error in either of the first two bits means no cycle opens.
- R3: During the window, `shift_stb_o` pulses once per bit time. Each pulse comes with one new `sdo_o` bit, sent MSB (word bit 15) first.
- R4: `cmd_sync_o` is set to 1 for a command sync and to 0 for a data sync when a cycle opens. It keeps that value until the next cycle opens or a reset.
- R5: The holding register loads the received word only on the rising edge of `take_data_no`. It loads even when the word is invalid. The decoder reset and the master reset leave it unchanged. Only `rst_ni` clears it.
- R6: `valid_word_no` goes low together with the rise of `take_data_no`, and only when all 17 bits are Manchester-valid and the ones count over data plus parity is odd.
- R7: `valid_word_no` stays low for 20*SPB clocks when no new sync arrives. When a new sync is detected first, it rises 3*SPB clocks after it fell, or on the next clock if that time has already passed.
- R8: `rt_en_o` is high only while `valid_word_no` is low, `cmd_sync_o` is high, and word bits 15:11 equal `term_addr_i`.
- R9: `bcast_o` is high under the same gating when word bits 15:11 are all ones.
- R10: `mode_code_o` is high under the same gating when word bits 9:5 are all zeros or all ones.
- R11: A low on `dec_rst_ni` or `mst_rst_ni` ends any cycle in progress without a transfer. It also forces `take_data_no` and `valid_word_no` high and `cmd_sync_o` low. Words that follow the reset are decoded normally.
- R12: With `self_test_i` high, the decoder takes its inputs from `enc_pos_i`/`enc_neg_i`. With it low, it takes them from `bus_pos_i`/`bus_neg_i`.
- R13: A low on `sel_lo_ni` drives register bits 7:0 onto `rx_data_o[7:0]`. A low on `sel_hi_ni` drives bits 15:8 onto `rx_data_o[15:8]`. A deselected byte is high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock, SPB cycles per bit |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| bus_pos_i | input | 1 | Receiver positive-state line |
| bus_neg_i | input | 1 | Receiver negative-state line |
| enc_pos_i | input | 1 | Encoder positive drive, used in self-test |
| enc_neg_i | input | 1 | Encoder negative drive, used in self-test |
| self_test_i | input | 1 | Selects the wraparound input pair |
| dec_rst_ni | input | 1 | Decoder reset, active low |
| mst_rst_ni | input | 1 | Master reset, active low |
| term_addr_i | input | 5 | Own terminal address |
| sel_lo_ni | input | 1 | Low byte output select, active low |
| sel_hi_ni | input | 1 | High byte output select, active low |
| rx_data_o | output | 16 | Tri-state parallel word output |
| take_data_no | output | 1 | Serial window, active low |
| shift_stb_o | output | 1 | One pulse per serial bit |
| sdo_o | output | 1 | Serial NRZ data |
| cmd_sync_o | output | 1 | 1 = command/status sync, 0 = data sync |
| valid_word_no | output | 1 | Good word flag, active low |
| rt_en_o | output | 1 | Own address matched |
| bcast_o | output | 1 | Broadcast address seen |
| mode_code_o | output | 1 | Mode-code subaddress seen |

## Verification
The bench sweeps all 32 address values and all 32 subaddress values. A design that compares the wrong field, or leaves out the sync-type gating, gives a wrong match, broadcast or mode-code result on at least one of them. It times the valid-word low phase both for a lone word and for back-to-back words. A design that ignores the following sync would hold the flag for the full 20 bit times, and one that releases too early shows a short count. It injects parity flips and coding errors into the first bit and into a later bit. A design that opens a window too early, or flags a corrupt word as good, is caught. Finally, it pulses both resets after a good word: a design that clears the holding register, or leaves the flags set, fails the read-back.

// File: rtl/mwd_pkg.sv
package mwd_pkg;
  typedef struct packed {
    logic vld;  // exactly one line high
    logic val;  // 1 = positive state
  } line_t;
endpackage

// File: rtl/mwd_line_sampler.sv
module mwd_line_sampler
  import mwd_pkg::*;
#(
  parameter int SPB = 12,
  parameter int TOL = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  pos_i,
  input  logic  neg_i,
  input  logic  arm_i,
  input  logic  restart_i,
  output line_t lvl_o,
  output logic  edge_o,
  output logic  pol_o
);
  localparam int SYNC_LEN = (3 * SPB) / 2;
  localparam int RUN_MAX  = SYNC_LEN + TOL + 1;
  localparam int RW       = $clog2(RUN_MAX + 1);
  localparam logic [RW-1:0] RUN_LO  = RW'(SYNC_LEN - TOL);
  localparam logic [RW-1:0] RUN_HI  = RW'(SYNC_LEN + TOL);
  localparam logic [RW-1:0] RUN_TOP = RW'(RUN_MAX);

  line_t cur_q, prev_q;
  logic [RW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      prev_q <= '0;
      run_q  <= '0;
    end else begin
      cur_q  <= '{vld: pos_i ^ neg_i, val: pos_i & ~neg_i};
      prev_q <= cur_q;
      // run_q = samples of the current level seen before this one
      if (restart_i || cur_q != prev_q) run_q <= RW'(1);
      else if (run_q != RUN_TOP)        run_q <= run_q + RW'(1);
    end
  end

  assign edge_o = arm_i && cur_q.vld && prev_q.vld && (cur_q.val != prev_q.val)
                  && (run_q >= RUN_LO) && (run_q <= RUN_HI);
  assign pol_o  = prev_q.val;
  assign lvl_o  = cur_q;
endmodule

// File: rtl/mwd_word_seq.sv
module mwd_word_seq
  import mwd_pkg::*;
#(
  parameter int SPB    = 12,
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  line_t             lvl_i,
  input  logic              edge_i,
  input  logic              pol_i,
  output logic              busy_o,
  output logic              restart_o,
  output logic              take_o,
  output logic              stb_o,
  output logic              sdo_o,
  output logic              cmd_o,
  output logic              done_o,
  output logic              good_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int SYNC_HALF = (3 * SPB) / 2;
  localparam int Q1 = SPB / 4;
  localparam int Q3 = SPB / 2 + SPB / 4;
  localparam int SW = $clog2(SYNC_HALF);
  localparam int BW = $clog2(WORD_W + 3);
  localparam logic [SW-1:0] SUB_Q1   = SW'(Q1);
  localparam logic [SW-1:0] SUB_Q3   = SW'(Q3);
  localparam logic [SW-1:0] SUB_BEND = SW'(SPB - 1);
  localparam logic [SW-1:0] SUB_SEND = SW'(SYNC_HALF - 1);
  localparam logic [BW-1:0] B_FIRST  = BW'(2);
  localparam logic [BW-1:0] B_PAR    = BW'(WORD_W);
  localparam logic [BW-1:0] B_LAST   = BW'(WORD_W + 1);
  localparam logic [BW-1:0] B_DONE   = BW'(WORD_W + 2);

  logic              busy_q, in_data_q, pol_q, bad_q;
  logic              take_q, stb_q, sdo_q, cmd_q;
  logic [SW-1:0]     sub_q;
  logic [BW-1:0]     bidx_q, pidx;
  line_t             h1_q;
  logic [WORD_W:0]   bits_q;
  logic              bit_ok, at_bit_start;

  assign bit_ok       = h1_q.vld && lvl_i.vld && (h1_q.val != lvl_i.val);
  assign at_bit_start = busy_q && in_data_q && (sub_q == '0);
  assign done_o       = at_bit_start && (bidx_q == B_DONE);
  assign restart_o    = at_bit_start && (bidx_q == B_LAST);
  assign pidx         = bidx_q - B_FIRST;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; in_data_q <= 1'b0; pol_q <= 1'b0; bad_q <= 1'b0;
      take_q <= 1'b0; stb_q <= 1'b0; sdo_q <= 1'b0; cmd_q <= 1'b0;
      sub_q <= '0; bidx_q <= '0; h1_q <= '0; bits_q <= '0;
    end else begin
      stb_q <= 1'b0;
      if (clr_i) begin
        busy_q <= 1'b0;
        take_q <= 1'b0;
        cmd_q  <= 1'b0;
      end else if (!busy_q) begin
        if (edge_i) begin
          busy_q    <= 1'b1;
          in_data_q <= 1'b0;
          sub_q     <= SW'(1);
          pol_q     <= pol_i;
          bad_q     <= 1'b0;
        end
      end else if (!in_data_q) begin
        // second sync half must hold the opposite state
        if (sub_q == SUB_Q3 && !(lvl_i.vld && lvl_i.val != pol_q)) busy_q <= 1'b0;
        else if (sub_q == SUB_SEND) begin
          in_data_q <= 1'b1;
          sub_q     <= '0;
          bidx_q    <= '0;
        end else sub_q <= sub_q + SW'(1);
      end else begin
        if (sub_q == SUB_BEND) begin
          sub_q  <= '0;
          bidx_q <= bidx_q + BW'(1);
        end else sub_q <= sub_q + SW'(1);
        if (sub_q == SUB_Q1) h1_q <= lvl_i;
        if (sub_q == SUB_Q3 && bidx_q <= B_PAR) begin
          bits_q[bidx_q] <= h1_q.val;
          if (!bit_ok) bad_q <= 1'b1;
        end
        if (at_bit_start && bidx_q >= B_FIRST && bidx_q <= B_LAST) begin
          stb_q <= 1'b1;
          sdo_q <= bits_q[pidx];
          if (bidx_q == B_FIRST) begin
            take_q <= 1'b1;
            cmd_q  <= pol_q;
          end
        end
        // early coding error: no receive cycle
        if (sub_q == SUB_Q3 && bidx_q < B_FIRST && !bit_ok) busy_q <= 1'b0;
        if (done_o) begin
          take_q <= 1'b0;
          busy_q <= 1'b0;
        end
      end
    end
  end

  for (genvar k = 0; k < WORD_W; k++) begin : g_word
    assign word_o[WORD_W-1-k] = bits_q[k];
  end

  assign good_o = !bad_q && (^bits_q);
  assign busy_o = busy_q;
  assign take_o = take_q;
  assign stb_o  = stb_q;
  assign sdo_o  = sdo_q;
  assign cmd_o  = cmd_q;
endmodule

// File: rtl/mwd_vw_timer.sv
module mwd_vw_timer #(
  parameter int SHORT_CYC = 36,
  parameter int LONG_CYC  = 240
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic done_i,
  input  logic good_i,
  input  logic sync_i,
  output logic vw_o
);
  localparam int CW = $clog2(LONG_CYC + 1);
  localparam logic [CW-1:0] C_SHORT = CW'(SHORT_CYC - 1);
  localparam logic [CW-1:0] C_LONG  = CW'(LONG_CYC - 1);

  logic          vw_q, seen_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vw_q <= 1'b0; seen_q <= 1'b0; cnt_q <= '0;
    end else if (clr_i) begin
      vw_q <= 1'b0; seen_q <= 1'b0;
    end else if (done_i && good_i) begin
      vw_q <= 1'b1; seen_q <= 1'b0; cnt_q <= '0;
    end else if (vw_q) begin
      if (sync_i) seen_q <= 1'b1;
      if (cnt_q == C_LONG || ((seen_q || sync_i) && cnt_q >= C_SHORT)) vw_q <= 1'b0;
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign vw_o = vw_q;
endmodule

// File: rtl/manch_word_rx.sv
module manch_word_rx
  import mwd_pkg::*;
#(
  parameter int SPB        = 12,
  parameter int WORD_W     = 16,
  parameter int ADDR_W     = 5,
  parameter int SA_W       = 5,
  parameter int SHORT_BITS = 3,
  parameter int LONG_BITS  = 20,
  parameter int SYNC_TOL   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_pos_i,
  input  logic              bus_neg_i,
  input  logic              enc_pos_i,
  input  logic              enc_neg_i,
  input  logic              self_test_i,
  input  logic              dec_rst_ni,
  input  logic              mst_rst_ni,
  input  logic [ADDR_W-1:0] term_addr_i,
  input  logic              sel_lo_ni,
  input  logic              sel_hi_ni,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              take_data_no,
  output logic              shift_stb_o,
  output logic              sdo_o,
  output logic              cmd_sync_o,
  output logic              valid_word_no,
  output logic              rt_en_o,
  output logic              bcast_o,
  output logic              mode_code_o
);
  localparam int LO_W   = WORD_W / 2;
  localparam int SA_LSB = WORD_W - ADDR_W - 1 - SA_W;

  logic              clr, in_pos, in_neg, edge_w, pol_w, busy_w, restart_w;
  logic              take_w, done_w, good_w, cmd_w, vw_w, cmd_word;
  line_t             lvl_w;
  logic [WORD_W-1:0] word_w, rank2_q;
  logic [ADDR_W-1:0] addr_f;
  logic [SA_W-1:0]   sa_f;

  assign clr    = ~dec_rst_ni | ~mst_rst_ni;
  assign in_pos = self_test_i ? enc_pos_i : bus_pos_i;
  assign in_neg = self_test_i ? enc_neg_i : bus_neg_i;

  mwd_line_sampler #(.SPB(SPB), .TOL(SYNC_TOL)) smp_i (
    .clk_i, .rst_ni, .pos_i(in_pos), .neg_i(in_neg),
    .arm_i(~busy_w & ~clr), .restart_i(restart_w),
    .lvl_o(lvl_w), .edge_o(edge_w), .pol_o(pol_w)
  );

  mwd_word_seq #(.SPB(SPB), .WORD_W(WORD_W)) seq_i (
    .clk_i, .rst_ni, .clr_i(clr), .lvl_i(lvl_w), .edge_i(edge_w), .pol_i(pol_w),
    .busy_o(busy_w), .restart_o(restart_w), .take_o(take_w), .stb_o(shift_stb_o),
    .sdo_o, .cmd_o(cmd_w), .done_o(done_w), .good_o(good_w), .word_o(word_w)
  );

  mwd_vw_timer #(.SHORT_CYC(SHORT_BITS * SPB), .LONG_CYC(LONG_BITS * SPB)) vw_i (
    .clk_i, .rst_ni, .clr_i(clr), .done_i(done_w), .good_i(good_w),
    .sync_i(edge_w), .vw_o(vw_w)
  );

  // second rank: only power-on reset clears it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rank2_q <= '0;
    else if (done_w) rank2_q <= word_w;
  end

  assign rx_data_o[LO_W-1:0]      = !sel_lo_ni ? rank2_q[LO_W-1:0] : 'z;
  assign rx_data_o[WORD_W-1:LO_W] = !sel_hi_ni ? rank2_q[WORD_W-1:LO_W] : 'z;

  assign addr_f   = rank2_q[WORD_W-1 -: ADDR_W];
  assign sa_f     = rank2_q[SA_LSB +: SA_W];
  assign cmd_word = vw_w & cmd_w;

  assign take_data_no  = ~take_w;
  assign cmd_sync_o    = cmd_w;
  assign valid_word_no = ~vw_w;
  assign rt_en_o       = cmd_word && (addr_f == term_addr_i);
  assign bcast_o       = cmd_word && (&addr_f);
  assign mode_code_o   = cmd_word && ((sa_f == '0) || (&sa_f));
endmodule

// File: rtl/manch_word_rx_chk.sv
module manch_word_rx_chk #(
  parameter int SPB       = 12,
  parameter int WORD_W    = 16,
  parameter int LONG_BITS = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dec_rst_ni,
  input logic              mst_rst_ni,
  input logic              take_data_no,
  input logic              valid_word_no,
  input logic              cmd_sync_o,
  input logic              rt_en_o,
  input logic              bcast_o,
  input logic              mode_code_o,
  input logic [WORD_W-1:0] rank2_q
);
  localparam int WIN  = WORD_W * SPB;
  localparam int LONG = LONG_BITS * SPB;

  logic [15:0] low_cnt, vw_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt <= '0;
      vw_cnt  <= '0;
    end else begin
      low_cnt <= take_data_no  ? '0 : low_cnt + 16'd1;
      vw_cnt  <= valid_word_no ? '0 : vw_cnt + 16'd1;
    end
  end

  assert_take_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(take_data_no) && $past(dec_rst_ni && mst_rst_ni)) |-> (low_cnt == 16'(WIN)));

  assert_rank2_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(take_data_no) |-> $stable(rank2_q));

  assert_vw_at_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(valid_word_no) |-> $rose(take_data_no));

  assert_vw_max_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_word_no |-> (vw_cnt < 16'(LONG)));

  assert_rt_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rt_en_o |-> (!valid_word_no && cmd_sync_o));

  assert_bcast_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bcast_o |-> (!valid_word_no && cmd_sync_o));

  assert_mode_gated_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_code_o |-> (!valid_word_no && cmd_sync_o));

  assert_dec_reset_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_rst_ni |=> (valid_word_no && !cmd_sync_o && take_data_no));
endmodule

bind manch_word_rx manch_word_rx_chk #(.SPB(SPB), .WORD_W(WORD_W), .LONG_BITS(LONG_BITS)) chk_i (.*);

// File: tb/manch_word_rx_tb_top.sv
module manch_word_rx_tb_top;
  localparam int SPB  = 12;
  localparam int HALF = SPB / 2;
  localparam int SYN  = (3 * SPB) / 2;
  localparam logic [4:0] MY_ADDR = 5'h0B;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_pos = 1'b1, bus_neg = 1'b1, enc_pos = 1'b1, enc_neg = 1'b1;
  logic self_test = 1'b0, dec_rst_n = 1'b1, mst_rst_n = 1'b1;
  logic sel_lo_n = 1'b1, sel_hi_n = 1'b1;
  logic [15:0] rx_data;
  logic take_n, stb, sdo, cmd_sync, vw_n, rt_en, bcast, mode_code;
  logic drv_enc = 1'b0;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  manch_word_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_pos_i(bus_pos), .bus_neg_i(bus_neg),
    .enc_pos_i(enc_pos), .enc_neg_i(enc_neg), .self_test_i(self_test),
    .dec_rst_ni(dec_rst_n), .mst_rst_ni(mst_rst_n), .term_addr_i(MY_ADDR),
    .sel_lo_ni(sel_lo_n), .sel_hi_ni(sel_hi_n), .rx_data_o(rx_data),
    .take_data_no(take_n), .shift_stb_o(stb), .sdo_o(sdo), .cmd_sync_o(cmd_sync),
    .valid_word_no(vw_n), .rt_en_o(rt_en), .bcast_o(bcast), .mode_code_o(mode_code)
  );

  // output monitor, sampled at falling edges
  logic take_prev = 1'b1;
  int take_cnt = 0, take_len = 0, take_falls = 0, vw_cnt = 0, vw_len = 0;
  logic [15:0] sdo_acc = '0;

  always @(negedge clk) begin
    if (take_prev && !take_n) begin
      take_falls++;
      sdo_acc = '0;
    end
    if (stb) sdo_acc = {sdo_acc[14:0], sdo};
    if (!take_n) take_cnt++;
    else if (take_cnt != 0) begin take_len = take_cnt; take_cnt = 0; end
    if (!vw_n) vw_cnt++;
    else if (vw_cnt != 0) begin vw_len = vw_cnt; vw_cnt = 0; end
    take_prev = take_n;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic drive_lvl(input logic v, input int n);
    repeat (n) begin
      @(negedge clk);
      if (drv_enc) begin enc_pos = v; enc_neg = ~v; end
      else         begin bus_pos = v; bus_neg = ~v; end
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      bus_pos = 1'b1; bus_neg = 1'b1; enc_pos = 1'b1; enc_neg = 1'b1;
    end
  endtask

  // err_k: bit index (0 = word bit 15, 16 = parity) sent without mid-bit transition
  task automatic send_word(input logic cmd, input logic [15:0] d, input logic par_flip,
                           input int err_k);
    drive_lvl(cmd, SYN);
    drive_lvl(~cmd, SYN);
    for (int k = 0; k < 17; k++) begin
      logic v;
      v = (k < 16) ? d[15-k] : (~(^d) ^ par_flip);
      drive_lvl(v, HALF);
      drive_lvl((k == err_k) ? v : ~v, HALF);
    end
  endtask

  function automatic logic [15:0] read_word();
    return rx_data;
  endfunction

  initial begin
    logic [15:0] pat [5];
    logic [15:0] w;
    int f0;
    pat[0] = 16'hA5C3; pat[1] = 16'h0000; pat[2] = 16'hFFFF;
    pat[3] = 16'h1234; pat[4] = 16'h8001;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    sel_lo_n = 1'b0; sel_hi_n = 1'b0;
    @(negedge clk);
    chk("R2 reset take", take_n, 1);
    chk("R6 reset vw", vw_n, 1);
    chk("R4 reset cmd", cmd_sync, 0);
    chk("R8 reset rt", rt_en, 0);
    chk("R5 reset reg", read_word(), 0);

    // data words of several patterns
    for (int i = 0; i < 5; i++) begin
      send_word(1'b0, pat[i], 1'b0, -1);
      idle(20);
      chk("R5 word", read_word(), pat[i]);
      chk("R3 serial", sdo_acc, pat[i]);
      chk("R2 window", take_len, 16 * SPB);
      chk("R4 data sync", cmd_sync, 0);
      chk("R6 good", vw_n, 0);
      chk("R8 data word no rt", rt_en, 0);
      idle(260);
      chk("R7 long release", vw_len, 20 * SPB);
      chk("R7 high after", vw_n, 1);
    end

    // address sweep on command words
    for (int a = 0; a < 32; a++) begin
      w = {a[4:0], 1'b1, 5'd3, 5'd2};
      send_word(1'b1, w, 1'b0, -1);
      idle(20);
      chk("R4 cmd sync", cmd_sync, 1);
      chk("R8 addr match", rt_en, (a == MY_ADDR) ? 1 : 0);
      chk("R9 broadcast", bcast, (a == 31) ? 1 : 0);
      chk("R10 no mode", mode_code, 0);
    end

    // subaddress sweep
    for (int s = 0; s < 32; s++) begin
      w = {MY_ADDR, 1'b1, s[4:0], 5'd7};
      send_word(1'b1, w, 1'b0, -1);
      idle(20);
      chk("R10 mode", mode_code, (s == 0 || s == 31) ? 1 : 0);
      chk("R8 own addr", rt_en, 1);
    end

    idle(260);
    chk("R8 gated after release", rt_en, 0);
    chk("R10 gated after release", mode_code, 0);

    // back-to-back words
    send_word(1'b0, 16'h3C3C, 1'b0, -1);
    send_word(1'b0, 16'h5AA5, 1'b0, -1);
    idle(20);
    chk("R7 short release", vw_len, 3 * SPB);
    chk("R5 second word", read_word(), 16'h5AA5);
    idle(260);

    // parity error
    send_word(1'b0, 16'h0F0F, 1'b1, -1);
    idle(20);
    chk("R6 parity error", vw_n, 1);
    chk("R5 loads bad word", read_word(), 16'h0F0F);
    idle(40);

    // late coding error
    send_word(1'b0, 16'h7777, 1'b0, 5);
    idle(20);
    chk("R6 coding error", vw_n, 1);
    chk("R2 window late error", take_len, 16 * SPB);
    idle(40);

    // error in first bit: no cycle
    f0 = take_falls;
    send_word(1'b0, 16'h1111, 1'b0, 0);
    idle(20);
    chk("R2 no cycle", take_falls, f0);
    chk("R5 unchanged", read_word(), 16'h7777);
    idle(40);

    // decoder reset
    send_word(1'b1, {MY_ADDR, 11'h044}, 1'b0, -1);
    idle(20);
    chk("R8 before reset", rt_en, 1);
    dec_rst_n = 1'b0;
    repeat (12) @(negedge clk);
    dec_rst_n = 1'b1;
    @(negedge clk);
    chk("R11 dec vw", vw_n, 1);
    chk("R11 dec cmd", cmd_sync, 0);
    chk("R11 dec rt", rt_en, 0);
    chk("R5 survives dec reset", read_word(), {MY_ADDR, 11'h044});

    // master reset mid-window
    send_word(1'b1, 16'hC0DE, 1'b0, -1);
    idle(20);
    fork
      send_word(1'b0, 16'hBEEF, 1'b0, -1);
      begin
        repeat (100) @(negedge clk);
        mst_rst_n = 1'b0;
        repeat (12) @(negedge clk);
        mst_rst_n = 1'b1;
      end
    join
    idle(20);
    chk("R11 mst take", take_n, 1);
    chk("R11 mst vw", vw_n, 1);
    chk("R5 survives mst reset", read_word(), 16'hC0DE);
    send_word(1'b0, 16'h2468, 1'b0, -1);
    idle(20);
    chk("R11 rearmed", read_word(), 16'h2468);

    // byte selects
    sel_hi_n = 1'b1;
    @(negedge clk);
    chk("R13 low byte", rx_data[7:0], 8'h68);
    sel_lo_n = 1'b1; sel_hi_n = 1'b0;
    @(negedge clk);
    chk("R13 high byte", rx_data[15:8], 8'h24);
    sel_lo_n = 1'b0;
    idle(260);

    // self-test wraparound
    self_test = 1'b1; drv_enc = 1'b1;
    send_word(1'b0, 16'h9ABC, 1'b0, -1);
    idle(20);
    chk("R12 wraparound", read_word(), 16'h9ABC);
    idle(260);
    self_test = 1'b0;
    f0 = take_falls;
    send_word(1'b0, 16'h4321, 1'b0, -1);
    idle(20);
    chk("R12 encoder ignored", take_falls, f0);
    chk("R12 reg kept", read_word(), 16'h9ABC);
    drv_enc = 1'b0;
    send_word(1'b0, 16'h4321, 1'b0, -1);
    idle(20);
    chk("R1 bus path", read_word(), 16'h4321);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule